// File: doc/BRIEF.md
# Flow-Through Burst Static RAM

This block is a single-clock synchronous static RAM whose words are split into 9-bit byte lanes. Every input (address, write data, strobes, write controls, enables) is captured on the rising clock edge. The addressed word is then read straight from the array, with no output register, so read data belongs to the cycle that follows the capturing edge.

An access starts from either of two address strobes: a processor-side strobe and a controller-side strobe. After the start, a 2-bit burst step counter produces the other three words of a four-word group. It steps only on cycles where the advance input is high. A mode input, sampled at the start, picks a linear or an interleaved order. Writes cover either the whole word (global write) or a chosen set of lanes (lane write enable plus per-lane selects). Three chip enables decide whether a strobe selects the device. A strobe seen while not selected ends the current access at that very edge.

Top module: `burst_sram`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rvalid` is low.
- R2: A strobe (`strobe_p` or `strobe_c`) at a clock edge where `ce_a`=1, `ce_b_n`=0 and `ce_c`=1 starts an access at `addr`. In the following cycle `rdata` holds that word and `rvalid` is high when `oe` is high and no write was done at that edge.
- R3: When both strobes are high, the processor strobe wins. No write is done at the edge where `strobe_p` starts an access, even if write controls are high.
- R4: A `strobe_c` start with a write request writes the start word at that same edge.
- R5: During an access, a clock edge with no strobe and `advance` low keeps the current address.
- R6: With `order_il`=0 at the start, step k of a burst (k = 0..3, modulo 4) uses low address bits (start + k) mod 4. The upper address bits stay fixed, and the fifth step returns to the start word.
- R7: With `order_il`=1 at the start, step k uses low address bits start XOR k.
- R8: `glob_wr`=1 writes all lanes, whatever `lane_wr_en` and `lane_sel` are.
- R9: With `glob_wr`=0 and `lane_wr_en`=1, only the lanes with `lane_sel[i]`=1 are written; lane i is bits [9i+8:9i]. `lane_sel` without `lane_wr_en` makes no write.
- R10: A strobe at an edge where any enable is inactive deselects the device. `rvalid` is low in the next cycle, no write is done, and writes on later unstrobed cycles are ignored until a new selected start.
- R11: `rvalid` is high only when an access is active, `oe` is high, and the last edge made no write.
- R12: A write on a cycle with `advance` high lands on the stepped address, not on the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Start address, taken when a strobe starts an access |
| wdata | input | LANES*LANE_W | Write data |
| strobe_p | input | 1 | Processor-side start strobe; has priority and makes no write at its start |
| strobe_c | input | 1 | Controller-side start strobe |
| advance | input | 1 | Step the burst counter |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| glob_wr | input | 1 | Write every lane |
| lane_wr_en | input | 1 | Enable for per-lane writes |
| lane_sel | input | LANES | Per-lane write selects |
| ce_a | input | 1 | Chip enable, active high |
| ce_b_n | input | 1 | Chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| oe | input | 1 | Output enable |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rvalid | output | 1 | Read data valid |

## Verification
Two things can land on one edge: a burst step and a write, and the two start strobes. The bench raises `advance` together with a lane write and then reads the group back. The write must sit on the stepped word, and the word before it must be unchanged. The bench also raises both strobes with global write asserted. It expects the old word back in the next cycle, then a late write on the next cycle that updates the same address.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int STEP_W = 2;

    // low address bits for burst step k from start s
    function automatic logic [STEP_W-1:0] burst_low(
        input logic [STEP_W-1:0] s,
        input logic [STEP_W-1:0] k,
        input logic              il
    );
        return il ? (s ^ k) : (s + k);
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [STEP_W-1:0] step,
    input  logic              il,
    output logic [ADDR_W-1:0] ea
);
    assign ea = {base[ADDR_W-1:STEP_W], burst_low(base[STEP_W-1:0], step, il)};
endmodule

// File: rtl/lane_mask_dec.sv
module lane_mask_dec #(
    parameter int LANES = 2
) (
    input  logic             glob_wr,
    input  logic             lane_wr_en,
    input  logic [LANES-1:0] lane_sel,
    output logic [LANES-1:0] mask,
    output logic             wr_req
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = glob_wr | (lane_wr_en & lane_sel[i]);
    end
    assign wr_req = |mask;
endmodule

// File: rtl/sram_lanes.sv
module sram_lanes #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        mask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[i]) begin
                mem[waddr] <= wdata[i*LANE_W +: LANE_W];
            end
        end

        assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    strobe_p,
    input  logic                    strobe_c,
    input  logic                    advance,
    input  logic                    order_il,
    input  logic                    glob_wr,
    input  logic                    lane_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic                    ce_a,
    input  logic                    ce_b_n,
    input  logic                    ce_c,
    input  logic                    oe,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              active;
        logic              wrote;
        logic              il;
        logic [STEP_W-1:0] cnt;
        logic [ADDR_W-1:0] base;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic [ADDR_W-1:0] cur_d, cur_q;
    logic              sel, start_p, start_c, desel, we;
    logic [LANES-1:0]  mask;
    logic              wr_req;
    logic [ADDR_W-1:0] ea;

    lane_mask_dec #(.LANES(LANES)) u_mask (
        .glob_wr    (glob_wr),
        .lane_wr_en (lane_wr_en),
        .lane_sel   (lane_sel),
        .mask       (mask),
        .wr_req     (wr_req)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .base (ctrl_d.base),
        .step (ctrl_d.cnt),
        .il   (ctrl_d.il),
        .ea   (ea)
    );

    always_comb begin
        sel     = ce_a & ~ce_b_n & ce_c;
        start_p = strobe_p & sel;
        start_c = ~strobe_p & strobe_c & sel;
        desel   = (strobe_p | strobe_c) & ~sel;

        ctrl_d       = ctrl_q;
        ctrl_d.wrote = 1'b0;
        if (start_p || start_c) begin
            ctrl_d.active = 1'b1;
            ctrl_d.base   = addr;
            ctrl_d.cnt    = '0;
            ctrl_d.il     = order_il;
        end else if (desel) begin
            ctrl_d.active = 1'b0;
        end else if (ctrl_q.active && advance) begin
            ctrl_d.cnt = ctrl_q.cnt + 1'b1;
        end

        we           = wr_req & ctrl_d.active & ~start_p;
        ctrl_d.wrote = we;
        cur_d        = ea;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cur_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            cur_q  <= cur_d;
        end
    end

    sram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .we    (we),
        .mask  (mask),
        .waddr (ea),
        .wdata (wdata),
        .raddr (cur_q),
        .rdata (rdata)
    );

    assign rvalid = ctrl_q.active & ~ctrl_q.wrote & oe;

    logic [DATA_W-1:0] unused_chk;
    assign unused_chk = '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              strobe_p,
    input logic              strobe_c,
    input logic              advance,
    input logic              ce_a,
    input logic              ce_b_n,
    input logic              ce_c,
    input logic              oe,
    input logic              rvalid,
    input logic              active,
    input logic [ADDR_W-1:0] cur_addr
);
    logic sel;
    assign sel = ce_a & ~ce_b_n & ce_c;

    assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_p | strobe_c) & sel |=> cur_addr == $past(addr));

    assert_adsp_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_p & sel |=> rvalid == oe);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active & ~strobe_p & ~strobe_c & ~advance |=> $stable(cur_addr));

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active & ~strobe_p & ~strobe_c & advance
        |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

    assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_p | strobe_c) & ~sel |=> ~rvalid);

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ~oe |-> ~rvalid);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .strobe_p (strobe_p),
    .strobe_c (strobe_c),
    .advance  (advance),
    .ce_a     (ce_a),
    .ce_b_n   (ce_b_n),
    .ce_c     (ce_c),
    .oe       (oe),
    .rvalid   (rvalid),
    .active   (ctrl_q.active),
    .cur_addr (cur_q)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
    localparam int AW = 10;
    localparam int NL = 2;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          strobe_p, strobe_c, advance, order_il, glob_wr, lane_wr_en;
    logic [NL-1:0] lane_sel;
    logic          ce_a, ce_b_n, ce_c, oe;
    logic [DW-1:0] rdata;
    logic          rvalid;

    logic [DW-1:0] model [1<<AW];
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .strobe_p(strobe_p), .strobe_c(strobe_c), .advance(advance),
        .order_il(order_il), .glob_wr(glob_wr), .lane_wr_en(lane_wr_en),
        .lane_sel(lane_sel), .ce_a(ce_a), .ce_b_n(ce_b_n), .ce_c(ce_c),
        .oe(oe), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        strobe_p = 0; strobe_c = 0; advance = 0; glob_wr = 0; lane_wr_en = 0;
        lane_sel = '0; ce_a = 1; ce_b_n = 0; ce_c = 1; oe = 1;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic gwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(); strobe_c = 1; addr = a; glob_wr = 1; wdata = d;
        tick(); model[a] = d; idle();
    endtask

    task automatic start_rd(input logic [AW-1:0] a, input logic il, input logic use_p);
        idle(); addr = a; order_il = il;
        if (use_p) strobe_p = 1; else strobe_c = 1;
        tick(); idle();
    endtask

    task automatic t_reset();
        idle(); order_il = 0;
        repeat (3) tick();
        check("R1 rvalid in reset", DW'(rvalid), DW'(0));
        rst_n = 1;
        tick();
        check("R1 rvalid after reset", DW'(rvalid), DW'(0));
    endtask

    task automatic t_write_read();
        gwrite(10'h033, 18'h2_5A5A);
        check("R11 rvalid after write", DW'(rvalid), DW'(0));
        start_rd(10'h033, 0, 1);
        check("R2 rvalid after start", DW'(rvalid), DW'(1));
        check("R4 strobe_c write data", rdata, model[10'h033]);
    endtask

    task automatic t_linear();
        for (int i = 0; i < 4; i++) gwrite(AW'(10'h040 + i), DW'(18'h1_0000 + 18'(i * 7 + 3)));
        start_rd(10'h042, 0, 1);
        check("R2 start word", rdata, model[10'h042]);
        for (int k = 1; k <= 4; k++) begin
            advance = 1; tick(); advance = 0;
            check("R6 linear step", rdata, model[10'h040 + ((2 + k) % 4)]);
            if (k == 2) begin
                tick();
                check("R5 hold without advance", rdata, model[10'h040 + ((2 + k) % 4)]);
            end
        end
        start_rd(10'h041, 0, 0);
        check("R2 strobe_c start word", rdata, model[10'h041]);
    endtask

    task automatic t_interleave();
        start_rd(10'h041, 1, 1);
        for (int k = 1; k < 4; k++) begin
            advance = 1; tick(); advance = 0;
            check("R7 interleaved step", rdata, model[10'h040 + (1 ^ k)]);
        end
    endtask

    task automatic t_both();
        idle(); strobe_p = 1; strobe_c = 1; addr = 10'h041; glob_wr = 1; wdata = 18'h3_FFFF;
        tick(); idle();
        check("R3 rvalid at processor start", DW'(rvalid), DW'(1));
        check("R3 no write at processor start", rdata, model[10'h041]);
        glob_wr = 1; wdata = 18'h1_5555;
        tick(); idle(); model[10'h041] = 18'h1_5555;
        check("R11 rvalid low after late write", DW'(rvalid), DW'(0));
        start_rd(10'h041, 0, 1);
        check("R3 late write lands", rdata, model[10'h041]);
    endtask

    task automatic t_lanes();
        gwrite(10'h050, 18'h3_FFFF);
        idle(); strobe_c = 1; addr = 10'h050; lane_wr_en = 1; lane_sel = 2'b01; wdata = '0;
        tick(); idle(); model[10'h050] = 18'h3_FE00;
        start_rd(10'h050, 0, 1);
        check("R9 lane0 only", rdata, model[10'h050]);
        idle(); strobe_c = 1; addr = 10'h050; lane_sel = 2'b10; wdata = '0;
        tick(); idle();
        check("R9 sel without enable rvalid", DW'(rvalid), DW'(1));
        check("R9 sel without enable data", rdata, model[10'h050]);
        idle(); strobe_c = 1; addr = 10'h050; lane_wr_en = 1; lane_sel = 2'b10; wdata = 18'h1_5400;
        tick(); idle(); model[10'h050] = 18'h1_5400 | 18'h0_01FF & model[10'h050];
        start_rd(10'h050, 0, 1);
        check("R9 lane1 only", rdata, model[10'h050]);
        idle(); strobe_c = 1; addr = 10'h050; glob_wr = 1; lane_sel = 2'b00; wdata = 18'h1_2345;
        tick(); idle(); model[10'h050] = 18'h1_2345;
        start_rd(10'h050, 0, 1);
        check("R8 global ignores lane selects", rdata, model[10'h050]);
    endtask

    task automatic t_adv_write();
        start_rd(10'h040, 0, 1);
        advance = 1; lane_wr_en = 1; lane_sel = 2'b11; wdata = 18'h0_0ABC;
        tick(); idle(); model[10'h041] = 18'h0_0ABC;
        check("R12 rvalid low on step write", DW'(rvalid), DW'(0));
        advance = 1; tick(); idle();
        check("R12 next step reads", rdata, model[10'h042]);
        start_rd(10'h041, 0, 1);
        check("R12 stepped word written", rdata, model[10'h041]);
        start_rd(10'h040, 0, 1);
        check("R12 previous word intact", rdata, model[10'h040]);
    endtask

    task automatic t_deselect();
        gwrite(10'h060, 18'h0_ABCD);
        for (int e = 0; e < 3; e++) begin
            idle(); addr = 10'h060; glob_wr = 1; wdata = 18'h3_0303;
            if (e == 1) strobe_p = 1; else strobe_c = 1;
            if (e == 0) ce_a = 0; else if (e == 1) ce_b_n = 1; else ce_c = 0;
            tick(); idle();
            check("R10 rvalid after deselect", DW'(rvalid), DW'(0));
            glob_wr = 1; wdata = 18'h3_0303;
            tick(); idle();
            check("R10 still deselected", DW'(rvalid), DW'(0));
            start_rd(10'h060, 0, 1);
            check("R10 no write while deselected", rdata, model[10'h060]);
        end
    endtask

    task automatic t_oe();
        start_rd(10'h060, 0, 1);
        check("R11 rvalid with oe", DW'(rvalid), DW'(1));
        oe = 0; #1;
        check("R11 oe low blocks rvalid", DW'(rvalid), DW'(0));
        oe = 1;
    endtask

    initial begin
        idle(); order_il = 0;
        tick();
        t_reset();
        t_write_read();
        t_linear();
        t_interleave();
        t_both();
        t_lanes();
        t_adv_write();
        t_deselect();
        t_oe();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule